// File: doc/BRIEF.md
# Hot-swap bus connect sequencer

This block is the digital controller of a two-sided I2C/SMBus hot-swap buffer. One side faces a live backplane bus and the other faces the bus on a plug-in card. While a card is being inserted the two buses are kept apart. The sequencer waits until both supplies are good. It then runs a timed precharge phase, and joins the buses only when the bus is demonstrably quiet. The bus is quiet when all four lines have stayed high for an idle window, or when a STOP condition is seen on the backplane while all lines are high.

Once joined, the block forwards lows across each SDA or SCL pair as open-drain pull-down requests. Each request records which side started the low, so that the block never keeps a line low only because of its own forwarded request. The analog parts of the buffer sit outside this block: offsets, slew control, comparators and current sources. The block drives their enables, namely precharge, connect and rise-time boost. An external pin selects whether the rise boost is used, and it also decides whether precharge stays on after connection. All line, supply and pin inputs pass through synchronizers of `SYNC_STAGES` flops. Every time constant is a parameter given in clock cycles.

Top module: `hsb_connect_seq`

## Requirements
- R1: The block leaves lockout only when both supply "above upper threshold" flags are 1, and the order in which they arrive does not matter. With only one of them set, precharge stays 0.
- R2: A 1 on either supply's "below lower threshold" flag returns the block to lockout and drops the connection. While both of a supply's flags are 0 (between the thresholds), an existing connection is kept.
- R3: In lockout, and during reset, `prechg_en_o`, `link_en_o`, `boost_en_o` and all four pull-down outputs are 0.
- R4: After lockout the block enters initialization for `EN_CYC` cycles. Initialization drives `prechg_en_o`=1 and `link_en_o`=0.
- R5: STOP and idle detection only start after initialization ends. A STOP seen during initialization does not cause a connection.
- R6: After initialization, the block connects once all four lines have been high for `IDLE_CYC` consecutive synchronized cycles. A low on any line restarts this count.
- R7: After initialization, a rising edge of backplane SDA while backplane SCL is high and all four lines are high (a STOP) connects at once, without waiting for the idle count.
- R8: While connected, `prechg_en_o` is 0 if the accelerator pin is 1, and 1 if the pin is 0.
- R9: `boost_en_o` is 1 exactly while connected and the accelerator pin is 1. One boost enable serves all four lines.
- R10: While connected, a low seen on a line drives the pull-down request of the other line of the same pair (backplane SDA with card SDA, backplane SCL with card SCL). When both sides go low together, the backplane side is taken as the origin.
- R11: When the originating side releases, the forwarded pull-down is released. The opposite request cannot start until `FWD_HOLD` cycles later, so both lines of a pair return high unless an external driver still holds one low. If a driver still holds a line low, that low is then forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bp_sda_i | input | 1 | Backplane SDA level |
| bp_scl_i | input | 1 | Backplane SCL level |
| cd_sda_i | input | 1 | Card SDA level |
| cd_scl_i | input | 1 | Card SCL level |
| sup1_up_i | input | 1 | Backplane supply above upper threshold |
| sup1_dn_i | input | 1 | Backplane supply below lower threshold |
| sup2_up_i | input | 1 | Card supply above upper threshold |
| sup2_dn_i | input | 1 | Card supply below lower threshold |
| acc_pin_i | input | 1 | Accelerator enable pin (1 = boost on) |
| prechg_en_o | output | 1 | Precharge enable |
| link_en_o | output | 1 | Connect enable |
| boost_en_o | output | 1 | Rise-time accelerator enable |
| bp_sda_pd_o | output | 1 | Pull-down request on backplane SDA |
| bp_scl_pd_o | output | 1 | Pull-down request on backplane SCL |
| cd_sda_pd_o | output | 1 | Pull-down request on card SDA |
| cd_scl_pd_o | output | 1 | Pull-down request on card SCL |

## Verification
The bench models each line as a wired-AND of an external driver and the block's own pull-down. With that model, a forwarding loop without origin tracking would hold a pair low forever after a release. The test plays a STOP during initialization, and a design that armed detection too early would connect almost at once. A short low is injected part-way through the idle window, and a counter that did not restart would connect too early. The bench also covers clock stretching handed from the card to the backplane, a supply sitting between the thresholds (a design without hysteresis would drop the link), and a connection with the accelerator pin low (precharge must stay on).

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_INIT  = 2'd1,
    ST_ARMED = 2'd2,
    ST_LINK  = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    ORG_NONE = 2'd0,
    ORG_UP   = 2'd1,
    ORG_DN   = 2'd2
  } org_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_rest
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= src;
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hsb_seq_fsm.sv
module hsb_seq_fsm
  import hsb_pkg::*;
#(
  parameter int EN_CYC   = 9000,
  parameter int IDLE_CYC = 7000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sup_up_i,
  input  logic [1:0] sup_dn_i,
  input  logic       all_hi_i,
  input  logic       bp_sda_i,
  input  logic       bp_scl_i,
  input  logic       acc_i,
  output logic       prechg_o,
  output logic       link_o,
  output logic       boost_o
);
  localparam int MAXC  = (EN_CYC > IDLE_CYC) ? EN_CYC : IDLE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] EN_LAST   = CNT_W'(EN_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             sda_prev_q;
  logic             stop_seen;

  assign stop_seen = all_hi_i & bp_scl_i & bp_sda_i & ~sda_prev_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    unique case (st_q)
      ST_LOCK: begin
        if (&sup_up_i) st_d = ST_INIT;
      end
      ST_INIT: begin
        if (cnt_q == EN_LAST) st_d = ST_ARMED;
        else                  cnt_d = cnt_q + 1'b1;
      end
      ST_ARMED: begin
        if (stop_seen || (all_hi_i && cnt_q == IDLE_LAST)) st_d = ST_LINK;
        else if (all_hi_i) cnt_d = cnt_q + 1'b1;
      end
      ST_LINK: begin
        cnt_en = (cnt_q != '0);
      end
    endcase
    if (|sup_dn_i) st_d = ST_LOCK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_LOCK;
      cnt_q      <= '0;
      sda_prev_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      sda_prev_q <= bp_sda_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign link_o   = (st_q == ST_LINK);
  assign boost_o  = link_o & acc_i;
  assign prechg_o = (st_q == ST_INIT) | (st_q == ST_ARMED) | (link_o & ~acc_i);

  // R2 R3
  property lock_drop_p;
    @(posedge clk) disable iff (!rst_n) (|sup_dn_i) |=> (!link_o && !prechg_o && !boost_o);
  endproperty
  lock_drop_chk: assert property (lock_drop_p);

  // R4
  property init_len_p;
    @(posedge clk) disable iff (!rst_n) (st_q == ST_INIT) |-> (cnt_q <= EN_LAST);
  endproperty
  init_len_chk: assert property (init_len_p);

  // R5 R6 R7
  property link_entry_p;
    @(posedge clk) disable iff (!rst_n) $rose(link_o) |-> ($past(st_q) == ST_ARMED);
  endproperty
  link_entry_chk: assert property (link_entry_p);

  // R8 R9
  property boost_prechg_p;
    @(posedge clk) disable iff (!rst_n) boost_o |-> !prechg_o;
  endproperty
  boost_prechg_chk: assert property (boost_prechg_p);
endmodule

// File: rtl/hsb_pair_fwd.sv
module hsb_pair_fwd
  import hsb_pkg::*;
#(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  input  logic up_i,
  input  logic dn_i,
  output logic up_pd_o,
  output logic dn_pd_o
);
  localparam int BW = $clog2(HOLD + 1);
  localparam logic [BW-1:0] HOLD_V = BW'(HOLD);

  org_t          org_q, org_d;
  logic [BW-1:0] blank_q, blank_d;

  always_comb begin
    org_d   = org_q;
    blank_d = blank_q;
    if (!link_i) begin
      org_d   = ORG_NONE;
      blank_d = '0;
    end else begin
      unique case (org_q)
        ORG_NONE: begin
          if (blank_q != '0) blank_d = blank_q - 1'b1;
          else if (!up_i)    org_d   = ORG_UP;
          else if (!dn_i)    org_d   = ORG_DN;
        end
        ORG_UP: begin
          if (up_i) begin
            org_d   = ORG_NONE;
            blank_d = HOLD_V;
          end
        end
        ORG_DN: begin
          if (dn_i) begin
            org_d   = ORG_NONE;
            blank_d = HOLD_V;
          end
        end
        default: org_d = ORG_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_q   <= ORG_NONE;
      blank_q <= '0;
    end else begin
      org_q   <= org_d;
      blank_q <= blank_d;
    end
  end

  assign dn_pd_o = (org_q == ORG_UP);
  assign up_pd_o = (org_q == ORG_DN);

  // R10
  property pd_needs_link_p;
    @(posedge clk) disable iff (!rst_n) (up_pd_o || dn_pd_o) |-> $past(link_i);
  endproperty
  pd_needs_link_chk: assert property (pd_needs_link_p);

  // R11
  property dn_release_p;
    @(posedge clk) disable iff (!rst_n) $fell(dn_pd_o) |=> !up_pd_o;
  endproperty
  dn_release_chk: assert property (dn_release_p);

  // R11
  property up_release_p;
    @(posedge clk) disable iff (!rst_n) $fell(up_pd_o) |=> !dn_pd_o;
  endproperty
  up_release_chk: assert property (up_release_p);
endmodule

// File: rtl/hsb_connect_seq.sv
module hsb_connect_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int EN_CYC      = 9000,
  parameter int IDLE_CYC    = 7000,
  parameter int FWD_HOLD    = SYNC_STAGES + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic cd_sda_i,
  input  logic cd_scl_i,
  input  logic sup1_up_i,
  input  logic sup1_dn_i,
  input  logic sup2_up_i,
  input  logic sup2_dn_i,
  input  logic acc_pin_i,
  output logic prechg_en_o,
  output logic link_en_o,
  output logic boost_en_o,
  output logic bp_sda_pd_o,
  output logic bp_scl_pd_o,
  output logic cd_sda_pd_o,
  output logic cd_scl_pd_o
);
  localparam int NIN = 9;
  localparam logic [NIN-1:0] SYNC_RST = 9'h0A0;

  logic [1:0]     rst_pipe;
  logic           rst_ln;
  logic [NIN-1:0] raw, syn;
  logic [1:0]     up_lvl, dn_lvl, up_pd, dn_pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ln = rst_pipe[1];

  assign raw = {acc_pin_i, sup2_dn_i, sup2_up_i, sup1_dn_i, sup1_up_i,
                cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i};

  hsb_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_ln),
    .d_i   (raw),
    .q_o   (syn)
  );

  hsb_seq_fsm #(.EN_CYC(EN_CYC), .IDLE_CYC(IDLE_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ln),
    .sup_up_i ({syn[6], syn[4]}),
    .sup_dn_i ({syn[7], syn[5]}),
    .all_hi_i (&syn[3:0]),
    .bp_sda_i (syn[0]),
    .bp_scl_i (syn[1]),
    .acc_i    (syn[8]),
    .prechg_o (prechg_en_o),
    .link_o   (link_en_o),
    .boost_o  (boost_en_o)
  );

  // pair 0 = SDA, pair 1 = SCL
  assign up_lvl = syn[1:0];
  assign dn_lvl = syn[3:2];

  for (genvar p = 0; p < 2; p++) begin : g_pair
    hsb_pair_fwd #(.HOLD(FWD_HOLD)) u_fwd (
      .clk     (clk),
      .rst_n   (rst_ln),
      .link_i  (link_en_o),
      .up_i    (up_lvl[p]),
      .dn_i    (dn_lvl[p]),
      .up_pd_o (up_pd[p]),
      .dn_pd_o (dn_pd[p])
    );
  end

  assign bp_sda_pd_o = up_pd[0];
  assign bp_scl_pd_o = up_pd[1];
  assign cd_sda_pd_o = dn_pd[0];
  assign cd_scl_pd_o = dn_pd[1];
endmodule

// File: tb/hsb_connect_seq_bench.sv
module hsb_connect_seq_bench;
  localparam int EN  = 20;
  localparam int IDL = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic m_sda, m_scl, c_sda, c_scl;
  logic s1u, s1d, s2u, s2d, acc;
  logic prechg, link, boost;
  logic bsda_pd, bscl_pd, csda_pd, cscl_pd;
  logic bp_sda, bp_scl, cd_sda, cd_scl;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #10 clk = ~clk;

  assign bp_sda = ~(m_sda | bsda_pd);
  assign bp_scl = ~(m_scl | bscl_pd);
  assign cd_sda = ~(c_sda | csda_pd);
  assign cd_scl = ~(c_scl | cscl_pd);

  hsb_connect_seq #(.SYNC_STAGES(2), .EN_CYC(EN), .IDLE_CYC(IDL), .FWD_HOLD(3)) u_hsb_connect_seq (
    .clk(clk), .rst_n(rst_n),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
    .sup1_up_i(s1u), .sup1_dn_i(s1d), .sup2_up_i(s2u), .sup2_dn_i(s2d),
    .acc_pin_i(acc),
    .prechg_en_o(prechg), .link_en_o(link), .boost_en_o(boost),
    .bp_sda_pd_o(bsda_pd), .bp_scl_pd_o(bscl_pd),
    .cd_sda_pd_o(csda_pd), .cd_scl_pd_o(cscl_pd)
  );

  // {m_sda,m_scl,c_sda,c_scl (1 = external low), exp bp_sda,bp_scl,cd_sda,cd_scl}
  localparam logic [7:0] FWD_TAB [11] = '{
    8'b0000_1111, 8'b1000_0101, 8'b0000_1111, 8'b0001_1010,
    8'b0101_1010, 8'b0100_1010, 8'b0000_1111, 8'b0010_0101,
    8'b0000_1111, 8'b1010_0101, 8'b0000_1111
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; m_sda = 0; m_scl = 0; c_sda = 0; c_scl = 0;
    s1u = 0; s1d = 1; s2u = 0; s2d = 1; acc = 1;
    cyc(4);
    chk("R3 reset prechg", prechg, 1'b0);
    chk("R3 reset link", link, 1'b0);
    chk("R3 reset boost", boost, 1'b0);
    chk("R3 reset pulldowns", bsda_pd | bscl_pd | csda_pd | cscl_pd, 1'b0);
    rst_n = 1'b1;
    cyc(4);

    // one supply only
    s1u = 1; s1d = 0;
    cyc(10);
    chk("R1 single supply prechg", prechg, 1'b0);

    // second supply, backplane SDA held low, STOP during init
    m_sda = 1; s2u = 1; s2d = 0;
    cyc(6);
    chk("R4 init prechg", prechg, 1'b1);
    chk("R4 init link", link, 1'b0);
    cyc(2);
    m_sda = 0;                     // STOP while initializing
    cyc(32);                       // ~N+40
    chk("R5 stop in init ignored", link, 1'b0);
    cyc(20);                       // ~N+60
    chk("R6 idle connect", link, 1'b1);
    chk("R8 prechg off with acc", prechg, 1'b0);
    chk("R9 boost on", boost, 1'b1);

    // forwarding table
    for (int i = 0; i < 11; i++) begin
      {m_sda, m_scl, c_sda, c_scl} = FWD_TAB[i][7:4];
      cyc(14);
      chk($sformatf("R10 R11 row %0d bp_sda", i), bp_sda, FWD_TAB[i][3]);
      chk($sformatf("R10 R11 row %0d bp_scl", i), bp_scl, FWD_TAB[i][2]);
      chk($sformatf("R10 R11 row %0d cd_sda", i), cd_sda, FWD_TAB[i][1]);
      chk($sformatf("R10 R11 row %0d cd_scl", i), cd_scl, FWD_TAB[i][0]);
    end

    // accelerator pin low
    acc = 0;
    cyc(5);
    chk("R8 prechg on without acc", prechg, 1'b1);
    chk("R9 boost off without acc", boost, 1'b0);
    chk("R8 still linked", link, 1'b1);
    acc = 1;
    cyc(5);

    // between thresholds keeps link, below lower drops it
    s2u = 0; s2d = 0;
    cyc(6);
    chk("R2 hysteresis keeps link", link, 1'b1);
    s2d = 1;
    cyc(5);
    chk("R2 drop link", link, 1'b0);
    chk("R3 lockout prechg", prechg, 1'b0);
    chk("R3 lockout boost", boost, 1'b0);
    chk("R3 lockout pulldowns", bsda_pd | bscl_pd | csda_pd | cscl_pd, 1'b0);

    // STOP connect
    m_sda = 1; s2d = 0; s2u = 1;
    cyc(EN + 8);
    chk("R7 armed waits with sda low", link, 1'b0);
    m_sda = 0;
    cyc(5);
    chk("R7 stop connect", link, 1'b1);

    // idle restart
    s1d = 1; s1u = 0;
    cyc(5);
    chk("R2 supply1 low drops link", link, 1'b0);
    s1d = 0; s1u = 1;
    cyc(43);
    c_scl = 1;
    cyc(3);
    c_scl = 0;
    cyc(19);                       // ~N+65
    chk("R6 low restarts idle count", link, 1'b0);
    cyc(25);                       // ~N+90
    chk("R6 connect after restart", link, 1'b1);

    finish_run();
  end
endmodule